// File: doc/BRIEF.md
# Tone-Burst Reply Receiver

This block listens to a tone-detect input from a single-wire tone-burst control bus and turns the reply from a peripheral into bytes. The length of each tone burst is measured with a timer that runs off a clock-divided tick. A long burst is read as a 0 and a short burst as a 1. Every group of nine bits forms one received byte. The first eight bits, most significant first, are the data. The ninth bit is an odd-parity bit.

Up to eight bytes are kept in a small store. Each byte carries its received parity bit and a flag that shows whether the parity check failed. A long silence closes the message and raises a completion flag. The host then reads the message through a strobe-driven read port, using two reads per byte: first the data, then a status word with the parity information. The block also reports how many bytes it has stored and whether any bytes were lost to overflow.

Top module: `tbr_reply_rx`

## Requirements
- R1: A tone burst longer than ZERO_MIN timer ticks decodes as a 0 and a shorter one as a 1. Each tick is TICK_DIV clock cycles. Bits are assembled most significant first, and the ninth bit of each group is taken as that byte's parity bit.
- R2: The parity-error flag of a stored byte is 1 exactly when the eight data bits and the parity bit together hold an even number of ones (odd parity expected).
- R3: Complete bytes are stored in order of arrival, up to DEPTH (8) of them, and `byte_count` equals the number stored.
- R4: A complete byte arriving when DEPTH bytes are already stored is discarded, and `overflow` goes to 1.
- R5: `rd_data` first presents the data byte at the read pointer. After one `rd_en` strobe it presents a status word with bit 0 holding the parity bit, bit 1 holding the parity-error flag and bits 7:2 at zero. After a second strobe the pointer moves to the next byte.
- R6: When tone has been absent for END_GAP ticks during a message, the message ends, `msg_done` goes to 1, and a byte with fewer than nine bits received is dropped.
- R7: The first tone burst after a message has ended starts a new message. It clears `byte_count`, `overflow`, `msg_done`, the read pointer and the read phase.
- R8: After reset, `byte_count`, `msg_done` and `overflow` are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_in | input | 1 | Tone-detect level from the analog front end (asynchronous) |
| rd_en | input | 1 | One-cycle read strobe that advances the read port |
| rd_data | output | 8 | Data byte or parity status word, depending on the read phase |
| byte_count | output | 4 | Number of bytes stored in the current message |
| msg_done | output | 1 | Message ended by a long silence |
| overflow | output | 1 | A byte was lost because the store was full |

## Verification
The hardest cases to reach from the ports are bytes arriving after the store is full and a message that ends part-way through a byte. Both depend on long, exactly timed tone sequences. The stimulus drives ten full bytes in one message, with the pulse widths of each bit chosen well away from the decode threshold. A separate message stops after four bits of its second byte, so the silence timer must close it with a partial byte pending. The bench also sends bytes with a deliberately wrong parity bit, so both values of the error flag are read back through the second read of each byte.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       par;
    logic       perr;
  } rx_byte_t;

  // Long tone means 0, short tone means 1.
  function automatic logic tone_bit(input logic [31:0] ticks, input int unsigned zero_min);
    return (ticks > zero_min) ? 1'b0 : 1'b1;
  endfunction

  // Odd parity over data and parity bit; returns 1 when the check fails.
  function automatic logic parity_err(input logic [7:0] data, input logic par);
    return ~(^{data, par});
  endfunction

endpackage

// File: rtl/tbr_tone_timer.sv
module tbr_tone_timer #(
  parameter int TICK_DIV = 50,
  parameter int END_GAP  = 6000,
  parameter int DUR_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tone_in,
  output logic             tone_rise,
  output logic             tone_fall,
  output logic [DUR_W-1:0] dur,
  output logic             gap_end
);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [DUR_W-1:0] GAP_L    = DUR_W'(END_GAP);
  localparam logic [DUR_W-1:0] GAP_M1   = DUR_W'(END_GAP - 1);

  logic [1:0]       sync_q;
  logic             tone_q;
  logic [PRE_W-1:0] pre_cnt;
  logic             tick;
  logic             edge_any;

  always_comb begin
    tone_rise = sync_q[1] & ~tone_q;
    tone_fall = ~sync_q[1] & tone_q;
    edge_any  = tone_rise | tone_fall;
    tick      = (pre_cnt == PRE_LAST);
    gap_end   = ~sync_q[1] & ~edge_any & tick & (dur == GAP_M1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      tone_q  <= 1'b0;
      pre_cnt <= '0;
      dur     <= '0;
    end else begin
      sync_q <= {sync_q[0], tone_in};
      tone_q <= sync_q[1];
      if (edge_any) begin
        pre_cnt <= '0;
        dur     <= '0;
      end else begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick && dur != GAP_L) dur <= dur + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tbr_bit_assembler.sv
module tbr_bit_assembler
  import tbr_pkg::*;
#(
  parameter int ZERO_MIN = 750,
  parameter int DUR_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tone_rise,
  input  logic             tone_fall,
  input  logic [DUR_W-1:0] dur,
  input  logic             gap_end,
  output logic             msg_start,
  output logic             msg_active,
  output logic             msg_done,
  output logic             byte_wr,
  output rx_byte_t         wr_byte
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  logic [7:0] shreg;
  logic [3:0] bit_cnt;
  logic       bit_val;

  always_comb begin
    msg_start    = tone_rise & ~msg_active;
    bit_val      = tone_bit(32'(dur), ZERO_MIN);
    byte_wr      = tone_fall & msg_active & (bit_cnt == LAST_BIT);
    wr_byte.data = shreg;
    wr_byte.par  = bit_val;
    wr_byte.perr = parity_err(shreg, bit_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      msg_active <= 1'b0;
      msg_done   <= 1'b0;
    end else if (msg_start) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      msg_active <= 1'b1;
      msg_done   <= 1'b0;
    end else if (gap_end) begin
      bit_cnt    <= '0;
      msg_active <= 1'b0;
      if (msg_active) msg_done <= 1'b1;
    end else if (tone_fall && msg_active) begin
      if (bit_cnt == LAST_BIT) begin
        bit_cnt <= '0;
      end else begin
        shreg   <= {shreg[6:0], bit_val};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tbr_reply_store.sv
module tbr_reply_store
  import tbr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr,
  input  rx_byte_t         wr_byte,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             rd_phase
);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

  rx_byte_t         mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr;
  rx_byte_t         cur;

  always_comb begin
    cur     = mem[rd_ptr];
    rd_data = rd_phase ? {6'b0, cur.perr, cur.par} : cur.data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
      rd_ptr   <= '0;
      rd_phase <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear) begin
      count    <= '0;
      overflow <= 1'b0;
      rd_ptr   <= '0;
      rd_phase <= 1'b0;
    end else begin
      if (wr) begin
        if (count < FULL) begin
          mem[count[PTR_W-1:0]] <= wr_byte;
          count <= count + 1'b1;
        end else begin
          overflow <= 1'b1;
        end
      end
      if (rd_en) begin
        rd_phase <= ~rd_phase;
        if (rd_phase) rd_ptr <= (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tbr_reply_rx.sv
module tbr_reply_rx
  import tbr_pkg::*;
#(
  parameter int TICK_DIV = 50,
  parameter int ZERO_MIN = 750,
  parameter int END_GAP  = 6000,
  parameter int DEPTH    = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tone_in,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] byte_count,
  output logic             msg_done,
  output logic             overflow
);
  localparam int DUR_W = $clog2(END_GAP + 1);
  localparam int PTR_W = $clog2(DEPTH);

  // Internal events brought out for the checker.
  logic             tone_rise;
  logic             tone_fall;
  logic [DUR_W-1:0] dur;
  logic             gap_end;
  logic             msg_start;
  logic             msg_active;
  logic             byte_wr;
  rx_byte_t         wr_byte;
  logic             rd_phase;

  tbr_tone_timer #(.TICK_DIV(TICK_DIV), .END_GAP(END_GAP), .DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tone_in(tone_in),
    .tone_rise(tone_rise), .tone_fall(tone_fall), .dur(dur), .gap_end(gap_end)
  );

  tbr_bit_assembler #(.ZERO_MIN(ZERO_MIN), .DUR_W(DUR_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .tone_rise(tone_rise), .tone_fall(tone_fall),
    .dur(dur), .gap_end(gap_end), .msg_start(msg_start), .msg_active(msg_active),
    .msg_done(msg_done), .byte_wr(byte_wr), .wr_byte(wr_byte)
  );

  tbr_reply_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(msg_start), .wr(byte_wr), .wr_byte(wr_byte),
    .rd_en(rd_en), .rd_data(rd_data), .count(byte_count), .overflow(overflow),
    .rd_phase(rd_phase)
  );

endmodule

// File: rtl/tbr_reply_rx_chk.sv
module tbr_reply_rx_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] byte_count,
  input logic             overflow,
  input logic             msg_done,
  input logic             msg_start,
  input logic             msg_active,
  input logic             gap_end,
  input logic             byte_wr,
  input logic             rd_en,
  input logic             rd_phase
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  p_count_le_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= FULL);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && byte_count < FULL && !msg_start) |=> byte_count == $past(byte_count) + 1'b1);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> byte_count == FULL);

  p_overflow_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && byte_count == FULL) |=> overflow);

  p_read_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !msg_start) |=> rd_phase != $past(rd_phase));

  p_done_on_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_end && msg_active) |=> msg_done);

  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && !msg_start) |=> msg_done);

  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> (byte_count == '0 && !overflow && !msg_done && !rd_phase));

endmodule

bind tbr_reply_rx tbr_reply_rx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_count(byte_count), .overflow(overflow),
  .msg_done(msg_done), .msg_start(msg_start), .msg_active(msg_active),
  .gap_end(gap_end), .byte_wr(byte_wr), .rd_en(rd_en), .rd_phase(rd_phase)
);

// File: tb/tbr_reply_rx_test.sv
module tbr_reply_rx_test;
  localparam int TICK_DIV = 4;
  localparam int ZERO_MIN = 10;
  localparam int END_GAP  = 40;
  localparam int DEPTH    = 8;
  // Bit timing in clock cycles: zero = long tone, one = short tone.
  localparam int ZERO_HI = 64, ZERO_LO = 32;
  localparam int ONE_HI  = 20, ONE_LO  = 76;
  localparam int SILENCE = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tone_in = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] byte_count;
  logic       msg_done;
  logic       overflow;

  int checks = 0;
  int fails  = 0;
  int msg_n  = 0;
  logic [9:0] exp_q [$];   // {data, parity, parity_error}

  always #10 clk = ~clk;

  tbr_reply_rx #(.TICK_DIV(TICK_DIV), .ZERO_MIN(ZERO_MIN), .END_GAP(END_GAP), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .tone_in(tone_in), .rd_en(rd_en), .rd_data(rd_data),
    .byte_count(byte_count), .msg_done(msg_done), .overflow(overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    tone_in = 1'b1;
    repeat (b ? ONE_HI : ZERO_HI) @(negedge clk);
    tone_in = 1'b0;
    repeat (b ? ONE_LO : ZERO_LO) @(negedge clk);
  endtask

  // Driver: sends one byte plus parity bit and pushes the expected entry.
  task automatic send_byte(input logic [7:0] d, input logic par);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(par);
    if (msg_n < DEPTH) exp_q.push_back({d, par, ~(^{d, par})});
    msg_n++;
  endtask

  task automatic end_msg();
    repeat (SILENCE) @(negedge clk);
  endtask

  // Monitor: reads every stored byte and compares against the queue.
  task automatic drain(input string tag);
    logic [9:0] e;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check({tag, " R1 R3 data"}, rd_data, e[9:2]);
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
      check({tag, " R2 R5 status"}, rd_data, {6'b0, e[0], e[1]});
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    end
    msg_n = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 count", byte_count, 0);
    check("R8 done", msg_done, 0);
    check("R8 overflow", overflow, 0);
    check("R8 rd_data", rd_data, 0);
    repeat (400) @(negedge clk);
    check("R6 no done without message", msg_done, 0);

    // Good-parity message
    send_byte(8'hA5, 1'b1);
    check("R6 not done mid message", msg_done, 0);
    send_byte(8'h00, 1'b1);
    send_byte(8'hFF, 1'b1);
    end_msg();
    check("R6 done", msg_done, 1);
    check("R3 count", byte_count, 3);
    check("R4 no overflow", overflow, 0);
    drain("msg1");

    // Bad parity mixed with good; first tone must clear the old message (R7)
    tone_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 done cleared", msg_done, 0);
    check("R7 count cleared", byte_count, 0);
    repeat (ZERO_HI - 6) @(negedge clk);
    tone_in = 1'b0;
    repeat (ZERO_LO) @(negedge clk);
    for (int i = 6; i >= 0; i--) send_bit(1'(8'h3C >> i));
    send_bit(1'b0);
    exp_q.push_back({8'h3C, 1'b0, 1'b1});
    send_byte(8'h01, 1'b0);
    send_byte(8'h80, 1'b1);
    end_msg();
    check("R2 count", byte_count, 3);
    drain("msg2");

    // Overflow: ten bytes
    for (int k = 0; k < 10; k++) send_byte(8'(8'h11 * (k + 1)), 1'b0);
    end_msg();
    check("R4 count full", byte_count, DEPTH);
    check("R4 overflow", overflow, 1);
    drain("msg3");
    check("R5 pointer wrapped", rd_data, 8'h11);

    // Partial byte dropped
    tone_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 overflow cleared", overflow, 0);
    repeat (ONE_HI - 6) @(negedge clk);
    tone_in = 1'b0;
    repeat (ONE_LO) @(negedge clk);
    for (int i = 6; i >= 0; i--) send_bit(1'(8'hC3 >> i));
    send_bit(1'b1);
    exp_q.push_back({8'hC3, 1'b1, 1'b0});
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    end_msg();
    check("R6 partial done", msg_done, 1);
    check("R6 partial count", byte_count, 1);
    drain("msg4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule